// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is the slave end of a three-wire control bus: an active-low frame line, a serial clock driven by the master and one bidirectional data line. Its own logic runs on that serial clock. Each frame starts with a nine-bit control word, which holds a fixed chip identifier, a direction bit and a four-bit register index. After the control word the block either takes in sixteen write bits or returns sixteen read bits from a register file that sits outside it.

The master changes the frame line and the data line on falling clock edges. The block samples on rising edges. On a read, the master lets go of the data line on the falling edge after the last control bit. The block starts to drive on the next rising edge, which gives half a cycle of turnaround. Read bits are launched on rising edges so the master can capture them on falling edges. The clock may run without stopping. Frames are marked by the frame line alone, and a complete frame occupies 26 rising edges.

The block is built around one state machine. The states are:
- `ST_IDLE`: no frame in progress.
- `ST_CTRL`: collecting the control word.
- `ST_TURN`: the turnaround cycle.
- `ST_READ`: driving read data.
- `ST_WRITE`: collecting write data.
- `ST_TAIL`: waiting for the frame line to rise.

The transitions are:
- `ST_IDLE` goes to `ST_CTRL` when the frame line is sampled low.
- `ST_CTRL` goes to `ST_TURN`, `ST_WRITE` or `ST_TAIL` on the ninth bit. The choice depends on the direction bit and on whether the chip identifier matches.
- `ST_TURN` goes to `ST_READ`.
- `ST_READ` and `ST_WRITE` go to `ST_TAIL` after their sixteenth bit.
- Every state other than `ST_IDLE` returns to `ST_IDLE` at any edge where the frame line is sampled high.

Top module: `tws_port`

## Requirements
- R1: After reset, `sdio_oe`, `sdio_out` and `reg_wr_en` are all low.
- R2: A frame begins at the rising edge where `frame_n` is sampled low, and that edge captures the first control bit. Control bits are taken on edges 1 to 9 in the order A7, A6, A5, RW, A4, A3, A2, A1, A0. RW = 0 selects a write and RW = 1 selects a read.
- R3: A frame is served only when A7..A4 = 0110. For any other identifier there is no register write, and `sdio_oe` stays low for the rest of the frame.
- R4: On a write, data bits are sampled on edges 10 to 25, most significant bit first. `reg_wr_en` is high for exactly one cycle, following edge 25. During that cycle `reg_wr_addr` = A3..A0 and `reg_wr_data` carries the sixteen bits.
- R5: On a read, `sdio_oe` stays low after edge 9 and rises at edge 10.
- R6: On a read, after edge p (p = 10..25) `sdio_out` equals bit 25-p of `reg_rd_data`. `reg_rd_addr` holds A3..A0 unchanged while the data line is driven.
- R7: `sdio_oe` drops at edge 26. The frame ends at the rising edge where `frame_n` is sampled high. Once that edge is past, a later low sample starts a new frame.
- R8: If `frame_n` is sampled high at any edge up to and including edge 25 of a write, the frame ends and no register write takes place.
- R9: If `frame_n` is sampled high during a read, `sdio_oe` goes low at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock from the master; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame line |
| sdio_in | input | 1 | Data line as seen at the pad input |
| sdio_out | output | 1 | Read bit to drive onto the data line |
| sdio_oe | output | 1 | Pad output enable for the data line |
| reg_rd_addr | output | 4 | Register index for the read mux |
| reg_rd_data | input | 16 | Contents of the selected register |
| reg_wr_en | output | 1 | Single-cycle register write strobe |
| reg_wr_addr | output | 4 | Register index for the write |
| reg_wr_data | output | 16 | Data to be written |

## Verification
The bench first reads all sixteen registers while they hold their start-up values. It then writes every register with a distinct computed word and reads them all back. Those two read passes tell apart the correct bit order and index decode from shifted or mirrored ones. Every wrong chip identifier is then sent with both directions, which shows which identifier bit the decode ignores and where the direction bit sits. Finally, every early rise of `frame_n` during a write and during a read is tried. This separates the edge that commits the write from its neighbours, and checks that the data line is released at each point of a read.

// File: rtl/tws_pkg.sv
package tws_pkg;

    localparam int TWS_DATA_W  = 16;
    localparam int TWS_ADDR_W  = 4;
    localparam int TWS_CHIP_W  = 4;
    localparam logic [TWS_CHIP_W-1:0] TWS_CHIP_ID = 4'b0110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_TURN,
        ST_READ,
        ST_WRITE,
        ST_TAIL
    } tws_state_e;

endpackage

// File: rtl/tws_bit_counter.sv
module tws_bit_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/tws_shifter.sv
module tws_shifter #(
    parameter int SH_W = 15
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_en,
    input  logic            bit_in,
    output logic [SH_W-1:0] sh
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= '0;
        end else if (shift_en) begin
            sh <= {sh[SH_W-2:0], bit_in};
        end
    end

endmodule

// File: rtl/tws_fsm.sv
module tws_fsm
    import tws_pkg::*;
#(
    parameter int CHIP_W = 4,
    parameter int CTRL_W = 9,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 4,
    parameter logic [CHIP_W-1:0] CHIP_ID = 4'b0110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic [CHIP_W:0]   hdr,        // identifier with direction bit inside
    input  logic [CNT_W-1:0]  cnt,
    output logic              cnt_clr,
    output logic              cnt_inc,
    output logic              load_addr,
    output logic              commit,
    output logic              drive
);

    localparam logic [CNT_W-1:0] LAST_CTRL = CNT_W'(CTRL_W - 2);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_W - 1);

    tws_state_e state, nxt;

    // The direction bit sits just below the top CHIP_W-1 identifier bits
    logic              is_read;
    logic [CHIP_W-1:0] chip_seen;
    logic              chip_hit;

    assign is_read   = hdr[1];
    assign chip_seen = {hdr[CHIP_W:2], hdr[0]};
    assign chip_hit  = (chip_seen == CHIP_ID);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt       = state;
        cnt_clr   = 1'b0;
        cnt_inc   = 1'b0;
        load_addr = 1'b0;
        commit    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (!frame_n) begin
                    nxt     = ST_CTRL;
                    cnt_clr = 1'b1;
                end
            end
            ST_CTRL: begin
                if (frame_n) begin
                    nxt = ST_IDLE;
                end else if (cnt == LAST_CTRL) begin
                    cnt_clr   = 1'b1;
                    load_addr = 1'b1;
                    if (!chip_hit) begin
                        nxt = ST_TAIL;
                    end else if (is_read) begin
                        nxt = ST_TURN;
                    end else begin
                        nxt = ST_WRITE;
                    end
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            ST_TURN: begin
                if (frame_n) begin
                    nxt = ST_IDLE;
                end else begin
                    nxt     = ST_READ;
                    cnt_clr = 1'b1;
                end
            end
            ST_READ: begin
                if (frame_n) begin
                    nxt = ST_IDLE;
                end else if (cnt == LAST_DATA) begin
                    nxt = ST_TAIL;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            ST_WRITE: begin
                if (frame_n) begin
                    nxt = ST_IDLE;
                end else if (cnt == LAST_DATA) begin
                    commit = 1'b1;
                    nxt    = ST_TAIL;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            ST_TAIL: begin
                if (frame_n) begin
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign drive = (state == ST_READ);

endmodule

// File: rtl/tws_port.sv
module tws_port
    import tws_pkg::*;
#(
    parameter int DATA_W = TWS_DATA_W,
    parameter int ADDR_W = TWS_ADDR_W,
    parameter int CHIP_W = TWS_CHIP_W,
    parameter logic [CHIP_W-1:0] CHIP_ID = TWS_CHIP_ID
) (
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              sdio_in,
    output logic              sdio_out,
    output logic              sdio_oe,
    output logic [ADDR_W-1:0] reg_rd_addr,
    input  logic [DATA_W-1:0] reg_rd_data,
    output logic              reg_wr_en,
    output logic [ADDR_W-1:0] reg_wr_addr,
    output logic [DATA_W-1:0] reg_wr_data
);

    localparam int CTRL_W = CHIP_W + 1 + ADDR_W;
    localparam int SH_W   = DATA_W - 1;
    localparam int CNT_W  = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] TOP_BIT = CNT_W'(DATA_W - 1);

    logic [SH_W-1:0]   sh;
    logic [CNT_W-1:0]  cnt;
    logic              cnt_clr, cnt_inc, load_addr, commit, drive;
    logic [CTRL_W-1:0] ctrl_word;
    logic [DATA_W-1:0] data_word;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  bit_sel;

    // The bit arriving on this edge completes both words
    assign ctrl_word = {sh[CTRL_W-2:0], sdio_in};
    assign data_word = {sh, sdio_in};

    tws_shifter #(.SH_W(SH_W)) u_shift (
        .clk      (sclk),
        .rst_n    (rst_n),
        .shift_en (!frame_n),
        .bit_in   (sdio_in),
        .sh       (sh)
    );

    tws_bit_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (sclk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .cnt   (cnt)
    );

    tws_fsm #(
        .CHIP_W  (CHIP_W),
        .CTRL_W  (CTRL_W),
        .DATA_W  (DATA_W),
        .CNT_W   (CNT_W),
        .CHIP_ID (CHIP_ID)
    ) u_fsm (
        .clk       (sclk),
        .rst_n     (rst_n),
        .frame_n   (frame_n),
        .hdr       (ctrl_word[CTRL_W-1:ADDR_W]),
        .cnt       (cnt),
        .cnt_clr   (cnt_clr),
        .cnt_inc   (cnt_inc),
        .load_addr (load_addr),
        .commit    (commit),
        .drive     (drive)
    );

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load_addr) begin
            addr_q <= ctrl_word[ADDR_W-1:0];
        end
    end

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            reg_wr_en   <= 1'b0;
            reg_wr_addr <= '0;
            reg_wr_data <= '0;
        end else begin
            reg_wr_en <= commit;
            if (commit) begin
                reg_wr_addr <= addr_q;
                reg_wr_data <= data_word;
            end
        end
    end

    // Read bits leave the live mux, most significant first
    assign bit_sel     = TOP_BIT - cnt;
    assign reg_rd_addr = addr_q;
    assign sdio_oe     = drive;
    assign sdio_out    = drive & reg_rd_data[bit_sel];

endmodule

// File: rtl/tws_port_chk.sv
module tws_port_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_n,
    input logic              sdio_oe,
    input logic              reg_wr_en,
    input logic [ADDR_W-1:0] reg_rd_addr
);

    // R4
    wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);

    // R8
    wr_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> $past(!frame_n));

    // R9
    oe_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sdio_oe |-> $past(!frame_n));

    // R6
    rd_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sdio_oe && $past(sdio_oe)) |-> $stable(reg_rd_addr));

    // R3
    oe_wr_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> !sdio_oe);

endmodule

bind tws_port tws_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (sclk),
    .rst_n       (rst_n),
    .frame_n     (frame_n),
    .sdio_oe     (sdio_oe),
    .reg_wr_en   (reg_wr_en),
    .reg_rd_addr (reg_rd_addr)
);

// File: tb/tws_port_tb.sv
module tws_port_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic        sdio_in = 1'b0;
    logic        sdio_out, sdio_oe, wr_en;
    logic [3:0]  rd_addr, wr_addr;
    logic [15:0] rd_data, wr_data;

    logic [15:0] mem [16];
    int          wr_cnt = 0;
    logic [3:0]  last_a;
    logic [15:0] last_d;
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    always #10 clk = ~clk;

    tws_port u_dut (
        .sclk        (clk),
        .rst_n       (rst_n),
        .frame_n     (frame_n),
        .sdio_in     (sdio_in),
        .sdio_out    (sdio_out),
        .sdio_oe     (sdio_oe),
        .reg_rd_addr (rd_addr),
        .reg_rd_data (rd_data),
        .reg_wr_en   (wr_en),
        .reg_wr_addr (wr_addr),
        .reg_wr_data (wr_data)
    );

    // Bench-side register file
    assign rd_data = mem[rd_addr];

    always @(posedge clk) begin
        if (wr_en) begin
            wr_cnt  = wr_cnt + 1;
            last_a  = wr_addr;
            last_d  = wr_data;
            mem[wr_addr] = wr_data;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input int a);
        return 16'((a * 16'h1357) ^ 16'hC0DE);
    endfunction

    // nlow: number of leading edges with frame_n low (25 = complete frame)
    task automatic frame(input logic [3:0] chip, input logic rw, input logic [3:0] a,
                         input logic [15:0] d, input int nlow);
        logic [8:0]  w;
        logic [15:0] exp_rd;
        logic        hit, exp_oe, exp_w;
        int          wr0;
        w      = {chip[3:1], rw, chip[0], a};
        exp_rd = mem[a];
        hit    = (chip == 4'b0110);
        wr0    = wr_cnt;
        for (int e = 1; e <= 27; e++) begin
            @(negedge clk);
            if (e > 1) begin
                int p = e - 1;
                exp_oe = hit && rw && p >= 10 && p <= 25 && p <= nlow;
                if (p == 9 && hit && rw)
                    chk("R5 turnaround oe", 32'(sdio_oe), 32'(exp_oe));
                else if (!hit)
                    chk("R3 oe on mismatch", 32'(sdio_oe), 32'(exp_oe));
                else if (nlow < 25)
                    chk("R9 oe on abort", 32'(sdio_oe), 32'(exp_oe));
                else if (p == 26)
                    chk("R7 oe at end", 32'(sdio_oe), 32'(exp_oe));
                else
                    chk("R5 oe", 32'(sdio_oe), 32'(exp_oe));
                if (exp_oe) begin
                    chk("R6 read bit", 32'(sdio_out), 32'(exp_rd[25-p]));
                    chk("R6 read addr", 32'(rd_addr), 32'(a));
                end
            end
            if (e <= 26) begin
                frame_n = (e <= nlow) ? 1'b0 : 1'b1;
                if (e <= 9)
                    sdio_in = w[9-e];
                else if (!rw && e <= 25)
                    sdio_in = d[25-e];
                else
                    sdio_in = 1'b0;
            end
        end
        exp_w = hit && !rw && nlow >= 25;
        if (!hit)
            chk("R3 write count", 32'(wr_cnt - wr0), 32'(exp_w));
        else if (nlow < 25)
            chk("R8 write count", 32'(wr_cnt - wr0), 32'(exp_w));
        else
            chk("R4 write count", 32'(wr_cnt - wr0), 32'(exp_w));
        if (exp_w) begin
            chk("R4 write addr", 32'(last_a), 32'(a));
            chk("R4 write data", 32'(last_d), 32'(d));
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 16'h0F00 + 16'(i);
        repeat (3) @(negedge clk);
        chk("R1 oe in reset", 32'(sdio_oe), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 oe", 32'(sdio_oe), 32'h0);
        chk("R1 out", 32'(sdio_out), 32'h0);
        chk("R1 wr_en", 32'(wr_en), 32'h0);

        // R2 R6: read start-up contents
        for (int a = 0; a < 16; a++) frame(4'b0110, 1'b1, 4'(a), 16'h0, 25);
        // R2 R4: write every register, then read back
        for (int a = 0; a < 16; a++) frame(4'b0110, 1'b0, 4'(a), pat(a), 25);
        for (int a = 0; a < 16; a++) begin
            chk("R4 stored", 32'(mem[a]), 32'(pat(a)));
            frame(4'b0110, 1'b1, 4'(a), 16'h0, 25);
        end
        // R3: every wrong identifier, both directions
        for (int c = 0; c < 16; c++) begin
            if (c != 6) begin
                frame(4'(c), 1'b0, 4'd3, 16'hFFFF, 25);
                frame(4'(c), 1'b1, 4'd3, 16'h0, 25);
            end
        end
        chk("R3 reg kept", 32'(mem[3]), 32'(pat(3)));
        // R8: write aborted at every edge
        for (int n = 1; n <= 24; n++) frame(4'b0110, 1'b0, 4'd5, 16'h1234, n);
        chk("R8 reg kept", 32'(mem[5]), 32'(pat(5)));
        // R9: read aborted at every edge
        for (int n = 1; n <= 24; n++) frame(4'b0110, 1'b1, 4'd9, 16'h0, n);
        // R7: frame after aborts still works
        frame(4'b0110, 1'b0, 4'd9, 16'h5AA5, 25);
        frame(4'b0110, 1'b1, 4'd9, 16'h0, 25);
        chk("R7 final reg", 32'(mem[9]), 32'h5AA5);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule